// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns a 16-bit compressed RV32 instruction into the 32-bit base instruction that does the same work. It also sorts every 16-bit code point into one of three kinds: a normal legal instruction, a HINT (legal, with no architectural effect beyond the expansion), or an illegal pattern. Illegal patterns are the reserved ones, the ones set aside for custom extensions, and any compressed encoding outside the groups handled here.

Several compressed opcodes share one encoding slot and are told apart only by operand values. The expander resolves each slot from its register and immediate fields. A word whose two low bits are both set is already a full-width instruction and is passed through untouched.

The decode is purely combinational. A parameter adds one output register stage, which is on by default, so the block can sit between fetch and decode without lengthening either path.

Top module: `cinst_expander`

## Requirements
- R1: An input whose bits [1:0] are 2'b11 produces the word {16'h0000, input} with both flags low.
- R2: With the output stage enabled (default), out_valid equals in_valid of the previous cycle and is 0 while rst_n is low. The word and flags for an accepted input appear in the cycle after it, and they hold while in_valid is low.
- R3: The stack-pointer word load (quadrant 2, funct3 010) becomes `lw rd, off(x2)`, where off = {ci[3:2], ci[12], ci[6:4], 2'b00} zero-extended; with rd = x0 it is illegal. The stack-pointer word store (quadrant 2, funct3 110) becomes `sw rs2, off(x2)`, where off = {ci[8:7], ci[12:9], 2'b00} and rs2 = ci[6:2].
- R4: Load-immediate (quadrant 1, funct3 010) becomes `addi rd, x0, imm`, where imm = sign-extended {ci[12], ci[6:2]}; rd = x0 sets the hint flag.
- R5: In quadrant 1, funct3 011, a zero 6-bit immediate is illegal. Otherwise rd = x2 gives `addi x2, x2, imm`, where imm = sign-extended {ci[12], ci[4:3], ci[5], ci[2], ci[6], 4'b0000}. Any other rd gives `lui rd, imm`, with the 6-bit field in result bits 17..12 and sign-extended from bit 17; rd = x0 sets hint.
- R6: Add-immediate (quadrant 1, funct3 000) becomes `addi rd, rd, imm`. rd = x0 with imm = 0 is a plain NOP with no hint. Exactly one of rd = x0 and imm = 0 sets hint.
- R7: Quadrant 0, funct3 000 becomes `addi rd', x2, u`, where u = {ci[10:7], ci[12:11], ci[5], ci[6], 2'b00} zero-extended; u = 0 is illegal, so the all-zero word is illegal.
- R8: Left shift (quadrant 2, funct3 000) becomes `slli rd, rd, ci[6:2]`. ci[12] = 1 is illegal. Otherwise a zero shift amount or rd = x0 sets hint.
- R9: Quadrant 1, funct3 100 with ci[11:10] = 00 becomes `srli rd', rd', sh` and with 01 becomes `srai rd', rd', sh`. ci[12] = 1 is illegal and sh = 0 sets hint.
- R10: Quadrant 2, funct3 100 with rs2 = ci[6:2] nonzero becomes `add rd, x0, rs2` when ci[12] = 0 and `add rd, rd, rs2` when ci[12] = 1. rd = x0 sets hint.
- R11: Quadrant 2, funct3 100 with rs2 = 0 splits four ways. With ci[12] = 0, a nonzero ci[11:7] gives `jalr x0, 0(rs1)` and a zero ci[11:7] is illegal. With ci[12] = 1, a nonzero ci[11:7] gives `jalr x1, 0(rs1)` and a zero ci[11:7] gives `ebreak` (32'h00100073).
- R12: Every 3-bit compressed register field selects register x8 + field.
- R13: An illegal result has a zero expanded word and a low hint flag. Every quadrant 0–2 encoding outside the groups above is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is present |
| in_insn | input | 16 | Compressed instruction, or the low half of a full-width one |
| out_valid | output | 1 | Output word is present |
| out_insn | output | 32 | Expanded instruction, zero when illegal |
| out_illegal | output | 1 | Code point is reserved, custom-reserved or unsupported |
| out_hint | output | 1 | Code point is a HINT |

## Verification
The bench presents every one of the 65,536 input words and compares each result with a model that builds the fields arithmetically, so no overlapping slot can hide. The weak spots are the operand-dependent splits: a design that tests the wrong field would treat the NOP as a hint, turn a zero-immediate stack adjust into a `lui`, or turn `ebreak` into `jalr x1`. Bit-scrambled immediates in the stack-pointer forms are another target, since one swapped pair only shows up on particular offsets. The same goes for the custom-reserved shift bit: a decoder that ignores it would emit a shift instead of flagging the word illegal.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam int CW        = 16;
  localparam int XW        = 32;
  localparam int RW        = 5;
  localparam int CRW       = 3;
  localparam int CREG_BASE = 8;

  localparam logic [6:0] OP_IMM    = 7'b0010011;
  localparam logic [6:0] OP_LUI    = 7'b0110111;
  localparam logic [6:0] OP_REG    = 7'b0110011;
  localparam logic [6:0] OP_LOAD   = 7'b0000011;
  localparam logic [6:0] OP_STORE  = 7'b0100011;
  localparam logic [6:0] OP_JALR   = 7'b1100111;
  localparam logic [6:0] OP_SYSTEM = 7'b1110011;

  localparam logic [RW-1:0] REG_SP   = RW'(2);
  localparam logic [RW-1:0] REG_LINK = RW'(1);

  typedef struct packed {
    logic [XW-1:0] word;
    logic          ill;
    logic          hint;
  } xres_t;

  // compressed register field -> full register number
  function automatic logic [RW-1:0] creg(input logic [CRW-1:0] f);
    return RW'(CREG_BASE) + RW'(f);
  endfunction

  function automatic logic [11:0] sext6(input logic [5:0] v);
    return {{6{v[5]}}, v};
  endfunction

  function automatic logic [XW-1:0] i_ins(input logic [11:0] imm, input logic [RW-1:0] rs1,
                                          input logic [2:0] f3, input logic [RW-1:0] rd,
                                          input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [XW-1:0] s_ins(input logic [11:0] imm, input logic [RW-1:0] rs2,
                                          input logic [RW-1:0] rs1, input logic [2:0] f3,
                                          input logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  function automatic logic [XW-1:0] r_ins(input logic [6:0] f7, input logic [RW-1:0] rs2,
                                          input logic [RW-1:0] rs1, input logic [2:0] f3,
                                          input logic [RW-1:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic logic [XW-1:0] u_ins(input logic [19:0] imm, input logic [RW-1:0] rd,
                                          input logic [6:0] op);
    return {imm, rd, op};
  endfunction

  // an illegal result always carries a blank word and no hint
  function automatic xres_t mk(input logic [XW-1:0] w, input logic il, input logic hn);
    xres_t r;
    r.word = il ? '0 : w;
    r.ill  = il;
    r.hint = il ? 1'b0 : hn;
    return r;
  endfunction
endpackage

// File: rtl/cx_quad0.sv
module cx_quad0
  import cx_pkg::*;
(
  input  logic [CW-1:0] ci,
  output xres_t         res
);
  logic [2:0]  f3;
  logic [11:0] uimm;

  assign f3   = ci[15:13];
  assign uimm = {2'b00, ci[10:7], ci[12:11], ci[5], ci[6], 2'b00};

  always_comb begin
    if (f3 == 3'b000)
      res = mk(i_ins(uimm, REG_SP, 3'b000, creg(ci[4:2]), OP_IMM), uimm == '0, 1'b0);
    else
      res = mk('0, 1'b1, 1'b0);
  end
endmodule

// File: rtl/cx_quad1.sv
module cx_quad1
  import cx_pkg::*;
(
  input  logic [CW-1:0] ci,
  output xres_t         res,
  output logic          sp_adjust
);
  logic [2:0]    f3;
  logic [RW-1:0] rd;
  logic [RW-1:0] rdp;
  logic [5:0]    imm6;
  logic          rd_zero;
  logic          imm_zero;
  logic [11:0]   sp_imm;
  logic [19:0]   up_imm;
  logic [6:0]    sh_f7;

  assign f3       = ci[15:13];
  assign rd       = ci[11:7];
  assign rdp      = creg(ci[9:7]);
  assign imm6     = {ci[12], ci[6:2]};
  assign rd_zero  = (rd == '0);
  assign imm_zero = (imm6 == '0);
  assign sp_imm   = {{3{ci[12]}}, ci[4:3], ci[5], ci[2], ci[6], 4'b0000};
  assign up_imm   = {{14{imm6[5]}}, imm6};
  assign sh_f7    = ci[10] ? 7'b0100000 : 7'b0000000;

  assign sp_adjust = (f3 == 3'b011) && (rd == REG_SP) && !imm_zero;

  always_comb begin
    case (f3)
      3'b000: res = mk(i_ins(sext6(imm6), rd, 3'b000, rd, OP_IMM), 1'b0, rd_zero ^ imm_zero);
      3'b010: res = mk(i_ins(sext6(imm6), '0, 3'b000, rd, OP_IMM), 1'b0, rd_zero);
      3'b011: begin
        if (imm_zero)       res = mk('0, 1'b1, 1'b0);
        else if (sp_adjust) res = mk(i_ins(sp_imm, REG_SP, 3'b000, REG_SP, OP_IMM), 1'b0, 1'b0);
        else                res = mk(u_ins(up_imm, rd, OP_LUI), 1'b0, rd_zero);
      end
      3'b100: begin
        if (ci[11] == 1'b0)
          res = mk(r_ins(sh_f7, ci[6:2], rdp, 3'b101, rdp, OP_IMM), ci[12], ci[6:2] == '0);
        else
          res = mk('0, 1'b1, 1'b0);
      end
      default: res = mk('0, 1'b1, 1'b0);
    endcase
  end
endmodule

// File: rtl/cx_quad2.sv
module cx_quad2
  import cx_pkg::*;
(
  input  logic [CW-1:0] ci,
  output xres_t         res,
  output logic          brk_hit
);
  logic [2:0]    f3;
  logic [RW-1:0] rd;
  logic [RW-1:0] rs2;
  logic          rd_zero;
  logic          rs2_zero;
  logic [11:0]   ld_off;
  logic [11:0]   st_off;

  assign f3       = ci[15:13];
  assign rd       = ci[11:7];
  assign rs2      = ci[6:2];
  assign rd_zero  = (rd == '0);
  assign rs2_zero = (rs2 == '0);
  assign ld_off   = {4'b0000, ci[3:2], ci[12], ci[6:4], 2'b00};
  assign st_off   = {4'b0000, ci[8:7], ci[12:9], 2'b00};
  assign brk_hit  = (f3 == 3'b100) && ci[12] && rd_zero && rs2_zero;

  always_comb begin
    case (f3)
      3'b000: res = mk(r_ins(7'b0, rs2, rd, 3'b001, rd, OP_IMM), ci[12], rs2_zero || rd_zero);
      3'b010: res = mk(i_ins(ld_off, REG_SP, 3'b010, rd, OP_LOAD), rd_zero, 1'b0);
      3'b110: res = mk(s_ins(st_off, rs2, REG_SP, 3'b010, OP_STORE), 1'b0, 1'b0);
      3'b100: begin
        if (!rs2_zero)
          res = mk(r_ins(7'b0, rs2, ci[12] ? rd : '0, 3'b000, rd, OP_REG), 1'b0, rd_zero);
        else if (brk_hit)
          res = mk(i_ins(12'd1, '0, 3'b000, '0, OP_SYSTEM), 1'b0, 1'b0);
        else
          res = mk(i_ins('0, rd, 3'b000, ci[12] ? REG_LINK : '0, OP_JALR), rd_zero, 1'b0);
      end
      default: res = mk('0, 1'b1, 1'b0);
    endcase
  end
endmodule

// File: rtl/cinst_expander.sv
module cinst_expander
  import cx_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] in_insn,
  output logic          out_valid,
  output logic [XW-1:0] out_insn,
  output logic          out_illegal,
  output logic          out_hint
);
  xres_t r_q0, r_q1, r_q2, r_sel;
  logic  sp_adjust;
  logic  brk_hit;

  cx_quad0 u_q0 (.ci(in_insn), .res(r_q0));
  cx_quad1 u_q1 (.ci(in_insn), .res(r_q1), .sp_adjust(sp_adjust));
  cx_quad2 u_q2 (.ci(in_insn), .res(r_q2), .brk_hit(brk_hit));

  always_comb begin
    case (in_insn[1:0])
      2'b00:   r_sel = r_q0;
      2'b01:   r_sel = r_q1;
      2'b10:   r_sel = r_q2;
      default: r_sel = mk({{(XW-CW){1'b0}}, in_insn}, 1'b0, 1'b0);
    endcase
  end

  logic [XW-1:0] comb_word;
  logic          comb_ill;
  logic          comb_hint;
  assign comb_word = r_sel.word;
  assign comb_ill  = r_sel.ill;
  assign comb_hint = r_sel.hint;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid   <= 1'b0;
          out_insn    <= '0;
          out_illegal <= 1'b0;
          out_hint    <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            out_insn    <= comb_word;
            out_illegal <= comb_ill;
            out_hint    <= comb_hint;
          end
        end
      end

      AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
      AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    end else begin : g_comb
      assign out_valid   = in_valid;
      assign out_insn    = comb_word;
      assign out_illegal = comb_ill;
      assign out_hint    = comb_hint;
    end
  endgenerate

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (in_insn[1:0] == 2'b11) |-> (comb_word == {16'h0000, in_insn}) && !comb_ill && !comb_hint); // R1
  AST_SPLOAD_X0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_insn[1:0] == 2'b10 && in_insn[15:13] == 3'b010 && in_insn[11:7] == 5'd0) |-> comb_ill); // R3
  AST_LI_HINT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_insn[1:0] == 2'b01 && in_insn[15:13] == 3'b010 && in_insn[11:7] == 5'd0) |-> comb_hint && !comb_ill); // R4
  AST_SPADJ_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_insn[1:0] == 2'b01 && sp_adjust) |-> (comb_word[11:7] == 5'd2) && (comb_word[19:15] == 5'd2)); // R5
  AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_insn == '0) |-> comb_ill); // R7
  AST_EBREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_insn[1:0] == 2'b10 && brk_hit) |-> (comb_word == 32'h0010_0073) && !comb_ill); // R11
  AST_ILL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    comb_ill |-> (comb_word == '0) && !comb_hint); // R13
endmodule

// File: tb/cinst_expander_test.sv
`timescale 1ns/1ps
module cinst_expander_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_insn = '0;
  logic        out_valid;
  logic [31:0] out_insn;
  logic        out_illegal;
  logic        out_hint;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic        exp_v = 1'b0;
  logic [31:0] exp_w = '0;
  logic        exp_il = 1'b0;
  logic        exp_hn = 1'b0;
  string       exp_tag = "R2";

  always #2 clk = ~clk;

  cinst_expander uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .out_valid(out_valid), .out_insn(out_insn), .out_illegal(out_illegal), .out_hint(out_hint)
  );

  function automatic int i_form(int imm, int rs1, int f3, int rd, int op);
    return ((imm & 'hfff) << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op;
  endfunction

  // reference model built from the requirement text
  task automatic ref_model(input logic [15:0] c, output logic [31:0] w,
                           output logic il, output logic hn);
    int q, f3, rd, rs2, rdp, rsp, imm6, sh, v, off, f7;
    q = int'(c[1:0]); f3 = int'(c[15:13]); rd = int'(c[11:7]); rs2 = int'(c[6:2]);
    rdp = 8 + int'(c[4:2]); rsp = 8 + int'(c[9:7]);            // R12
    imm6 = int'(c[6:2]) - (c[12] ? 32 : 0);
    sh = int'(c[6:2]);
    w = '0; il = 1'b0; hn = 1'b0;
    if (q == 3) begin
      w = {16'h0000, c};
    end else if (q == 0) begin
      v = int'(c[10:7]) * 64 + int'(c[12:11]) * 16 + int'(c[5]) * 8 + int'(c[6]) * 4;
      if (f3 != 0 || v == 0) il = 1'b1;
      else w = 32'(i_form(v, 2, 0, rdp, 'h13));
    end else if (q == 1) begin
      case (f3)
        0: begin w = 32'(i_form(imm6, rd, 0, rd, 'h13)); hn = (rd == 0) != (imm6 == 0); end
        2: begin w = 32'(i_form(imm6, 0, 0, rd, 'h13)); hn = (rd == 0); end
        3: begin
          if (imm6 == 0) il = 1'b1;
          else if (rd == 2) begin
            v = (c[12] ? -512 : 0) + int'(c[4:3]) * 128 + int'(c[5]) * 64 + int'(c[2]) * 32 + int'(c[6]) * 16;
            w = 32'(i_form(v, 2, 0, 2, 'h13));
          end else begin
            w = 32'(((imm6 & 'hfffff) << 12) | (rd << 7) | 'h37);
            hn = (rd == 0);
          end
        end
        4: begin
          if (c[11] || c[12]) il = 1'b1;
          else begin
            f7 = c[10] ? 'h20 : 0;
            w = 32'((f7 << 25) | (sh << 20) | (rsp << 15) | (5 << 12) | (rsp << 7) | 'h13);
            hn = (sh == 0);
          end
        end
        default: il = 1'b1;
      endcase
    end else begin
      case (f3)
        0: begin
          if (c[12]) il = 1'b1;
          else begin
            w = 32'((sh << 20) | (rd << 15) | (1 << 12) | (rd << 7) | 'h13);
            hn = (sh == 0) || (rd == 0);
          end
        end
        2: begin
          off = int'(c[3:2]) * 64 + int'(c[12]) * 32 + int'(c[6:4]) * 4;
          if (rd == 0) il = 1'b1;
          else w = 32'(i_form(off, 2, 2, rd, 'h03));
        end
        6: begin
          off = int'(c[8:7]) * 64 + int'(c[12:9]) * 4;
          w = 32'(((off >> 5) << 25) | (rs2 << 20) | (2 << 15) | (2 << 12) | ((off & 31) << 7) | 'h23);
        end
        4: begin
          if (rs2 != 0) begin
            w = 32'((rs2 << 20) | ((c[12] ? rd : 0) << 15) | (rd << 7) | 'h33);
            hn = (rd == 0);
          end else if (rd == 0) begin
            if (c[12]) w = 32'h0010_0073; else il = 1'b1;
          end else begin
            w = 32'(i_form(0, rd, 0, c[12] ? 1 : 0, 'h67));
          end
        end
        default: il = 1'b1;
      endcase
    end
  endtask

  function automatic string tag_of(input logic [15:0] c);
    int f3 = int'(c[15:13]);
    case (c[1:0])
      2'b11: return "R1";
      2'b00: return (f3 == 0) ? "R7" : "R13";
      2'b01: case (f3)
               0: return "R6";
               2: return "R4";
               3: return "R5";
               4: return c[11] ? "R13" : "R9";
               default: return "R13";
             endcase
      default: case (f3)
               0: return "R8";
               2, 6: return "R3";
               4: return (c[6:2] == 0) ? "R11" : "R10";
               default: return "R13";
             endcase
    endcase
  endfunction

  // compare the previous cycle's expectation, then drive the next input
  task automatic apply(input logic v, input logic [15:0] c, input string tag);
    @(negedge clk);
    compared++;
    if (out_valid !== exp_v) begin
      mismatched++;
      $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, exp_v);
    end
    if (exp_v) begin
      compared++;
      if (out_insn !== exp_w || out_illegal !== exp_il || out_hint !== exp_hn) begin
        mismatched++;
        $display("FAIL %s word/ill/hint actual=%h/%0b/%0b expected=%h/%0b/%0b",
                 exp_tag, out_insn, out_illegal, out_hint, exp_w, exp_il, exp_hn);
      end
    end
    exp_v = v;
    exp_tag = tag;
    if (v) ref_model(c, exp_w, exp_il, exp_hn);
    in_valid = v;
    in_insn = c;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (out_valid !== 1'b0 || out_illegal !== 1'b0 || out_hint !== 1'b0) begin
      mismatched++;
      $display("FAIL R2 reset state actual=%0b%0b%0b expected=000", out_valid, out_illegal, out_hint);
    end
    rst_n = 1'b1;
    apply(1'b1, 16'h0000, "R7");      // all-zero word illegal
    apply(1'b1, 16'h9002, "R11");     // ebreak
    apply(1'b1, 16'h8002, "R11");     // jr x0 reserved
    apply(1'b1, 16'h0001, "R6");      // plain NOP, no hint
    apply(1'b0, 16'h0001, "R2");      // idle cycle
    apply(1'b1, 16'h6101, "R5");      // zero-immediate stack adjust reserved
    apply(1'b1, 16'h1ffc, "R12");     // addi4spn to x15
    apply(1'b1, 16'h8385, "R12");     // srli on x15
    apply(1'b1, 16'h1082, "R8");      // custom-reserved left shift
    apply(1'b1, 16'h4002, "R3");      // stack load to x0
    apply(1'b1, 16'h4001, "R4");      // li x0 hint
    apply(1'b1, 16'hdead, "R13");     // outside covered groups
    apply(1'b1, 16'hbeef, "R1");
    for (int k = 0; k < 65536; k++) begin
      if (k % 997 == 0) apply(1'b0, 16'(k), "R2");
      apply(1'b1, 16'(k), tag_of(16'(k)));
    end
    apply(1'b0, 16'h0000, "R2");
    apply(1'b0, 16'h0000, "R2");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule